// File: doc/BRIEF.md
# Memory Request Controller

This block is a small synchronous sequencer that sits between a client and a memory port. The client raises single-cycle write or read request pulses. The controller answers each accepted request with an address-latch strobe in the same cycle. It then steps the memory through a short access and closes it with a one-cycle acknowledge.

Only the idle state accepts work. When both request lines are high in that state, the write is taken and the read is discarded. A write spends one quiet cycle before the read/write line goes low together with the acknowledge. A read acknowledges on the cycle after the strobe, and the read/write line stays high throughout.

There is no request queue. A pulse that arrives while an access is running is lost. A synchronous clear, or the active-low reset, cancels any access that is running. Either one holds the three outputs in their resting pattern.

Top module: `mem_req_ctl`

## Requirements
- R1: While `clr` is 1 (and reset is released), the outputs read `addr_latch`=0, `rw_n`=1, `ack`=0 whatever the request lines do. On the next rising edge the controller is back in idle.
- R2: While `rst_n` is 0, the outputs read `addr_latch`=0, `rw_n`=1, `ack`=0. After a rising edge with `rst_n` low, the controller is idle.
- R3: In idle with no clear, a request on `wr_req` or `rd_req` raises `addr_latch` combinationally in that same cycle.
- R4: When `wr_req` and `rd_req` are both 1 in idle, a write sequence is run and the read is ignored.
- R5: An accepted write produces three cycles and then idle. The strobe cycle is the first. The second has all outputs inactive (0,1,0). The third has `rw_n`=0 and `ack`=1.
- R6: An accepted read produces two cycles and then idle. The strobe cycle is the first. The second has `ack`=1 and `rw_n`=1.
- R7: `rw_n` is 0 only in the acknowledge cycle of a write and is 1 at all other times.
- R8: `ack` is 1 for exactly one cycle per served request.
- R9: Requests arriving when the controller is not idle raise no strobe. They are dropped, not queued.
- R10: A clear during a running access aborts it. No acknowledge follows for that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear, active high |
| wr_req | input | 1 | Write request pulse |
| rd_req | input | 1 | Read request pulse |
| addr_latch | output | 1 | Address-latch strobe, combinational in idle |
| rw_n | output | 1 | Read/write line, low for write |
| ack | output | 1 | One-cycle acknowledge |

## Verification
The bench goes after several corner cases:
- Simultaneous requests: a design without write priority would acknowledge one cycle early with `rw_n` high.
- Requests during the wait or acknowledge cycles: a design that queued them would strobe again, or acknowledge twice.
- Clear in the middle of a write, and a request while clear is held: a design with an ungated strobe or an unreset state would leak a strobe or a late acknowledge.
- Every three-cycle pattern of clear, write and read: compared each cycle against a model computed from the requirements, which catches any off-by-one in the sequence lengths.

// File: rtl/mrc_pkg.sv
// Package: shared state encoding for the memory request controller.
// Assumes two state bits are enough for the four states; idle is zero.
package mrc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_WAIT = 2'd1,
        ST_WR_ACK  = 2'd2,
        ST_RD_ACK  = 2'd3
    } mrc_state_e;
endpackage

// File: rtl/mrc_arbiter.sv
// Module: mrc_arbiter
// Picks at most one request to serve. Write wins over read.
// Assumes 'enable' is high only in idle with no clear or reset.
module mrc_arbiter (
    input  logic enable,
    input  logic wr_req,
    input  logic rd_req,
    output logic grant_wr,
    output logic grant_rd
);
    // Fixed-priority grant: a write always masks a read.
    always_comb begin
        grant_wr = enable & wr_req;
        grant_rd = enable & rd_req & ~wr_req;
    end
endmodule

// File: rtl/mrc_state_reg.sv
// Module: mrc_state_reg
// Holds the controller state and computes the next state from the grants.
// Assumes the grants are already qualified by idle, clear and reset.
module mrc_state_reg
    import mrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       grant_wr,
    input  logic       grant_rd,
    output mrc_state_e state_q
);
    mrc_state_e state_d;

    // Next-state selection: idle branches on grants, other states step forward.
    always_comb begin
        case (state_q)
            ST_IDLE:    state_d = grant_wr ? ST_WR_WAIT :
                                  (grant_rd ? ST_RD_ACK : ST_IDLE);
            ST_WR_WAIT: state_d = ST_WR_ACK;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset and synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/mrc_out_decode.sv
// Module: mrc_out_decode
// Turns the state and the idle grant into the three memory-side outputs.
// Assumes 'hold' is high during clear or reset and forces the rest pattern.
module mrc_out_decode
    import mrc_pkg::*;
(
    input  mrc_state_e state_q,
    input  logic       hold,
    input  logic       any_grant,
    output logic       addr_latch,
    output logic       rw_n,
    output logic       ack
);
    // Output decode: strobe from the grant, the rest from the state alone.
    always_comb begin
        addr_latch = any_grant & ~hold;
        rw_n       = hold | (state_q != ST_WR_ACK);
        ack        = ~hold & ((state_q == ST_WR_ACK) | (state_q == ST_RD_ACK));
    end
endmodule

// File: rtl/mem_req_ctl.sv
// Module: mem_req_ctl (top)
// Memory request controller. Accepts write/read pulses in idle, strobes the
// address at once, then runs a write (wait, ack with rw_n low) or a read
// (ack with rw_n high). Assumes single-cycle request pulses from the client.
module mem_req_ctl
    import mrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wr_req,
    input  logic rd_req,
    output logic addr_latch,
    output logic rw_n,
    output logic ack
);
    mrc_state_e state_q;
    logic       hold;
    logic       in_idle;
    logic       grant_wr;
    logic       grant_rd;

    // Qualifiers: clear or reset hold the outputs; idle gates new requests.
    always_comb begin
        hold    = clr | ~rst_n;
        in_idle = (state_q == ST_IDLE);
    end

    mrc_arbiter u_arb (
        .enable   (in_idle & ~hold),
        .wr_req   (wr_req),
        .rd_req   (rd_req),
        .grant_wr (grant_wr),
        .grant_rd (grant_rd)
    );

    mrc_state_reg u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .grant_wr (grant_wr),
        .grant_rd (grant_rd),
        .state_q  (state_q)
    );

    mrc_out_decode u_dec (
        .state_q    (state_q),
        .hold       (hold),
        .any_grant  (grant_wr | grant_rd),
        .addr_latch (addr_latch),
        .rw_n       (rw_n),
        .ack        (ack)
    );
endmodule

// File: rtl/mem_req_ctl_chk.sv
// Module: mem_req_ctl_chk
// Protocol checker for mem_req_ctl. It sees the ports and the idle flag.
// It is attached by the bind statement at the end of this file.
module mem_req_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic clr,
    input logic wr_req,
    input logic rd_req,
    input logic addr_latch,
    input logic rw_n,
    input logic ack,
    input logic in_idle
);
    // R1
    clear_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (!addr_latch && rw_n && !ack));
    // R2
    reset_rest_chk: assert property (@(posedge clk)
        !rst_n |-> (!addr_latch && rw_n && !ack));
    // R2
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> in_idle);
    // R3
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && !clr && (wr_req || rd_req)) |-> addr_latch);
    // R4
    wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_latch && wr_req && rd_req) |=> (clr || !ack));
    // R5
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_latch && wr_req) |=> (clr || (!addr_latch && rw_n && !ack)));
    // R6
    rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_latch && !wr_req) |=> (clr || (ack && rw_n)));
    // R7
    rw_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_n |-> ack);
    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_idle |-> !addr_latch);
    // R10
    clr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !ack);
endmodule

bind mem_req_ctl mem_req_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .wr_req     (wr_req),
    .rd_req     (rd_req),
    .addr_latch (addr_latch),
    .rw_n       (rw_n),
    .ack        (ack),
    .in_idle    (in_idle)
);

// File: tb/tb_mem_req_ctl.sv
// Bench: directed sequences plus an exhaustive sweep of three-cycle input
// patterns, compared against a model written from the requirements.
module tb_mem_req_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic wr_req = 1'b0;
    logic rd_req = 1'b0;
    logic addr_latch, rw_n, ack;
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    int   mstate = 0;   // 0 idle, 1 write wait, 2 write ack, 3 read ack

    always #5 clk = ~clk;

    mem_req_ctl dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_req(wr_req), .rd_req(rd_req),
        .addr_latch(addr_latch), .rw_n(rw_n), .ack(ack)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 60000) begin
            $display("FAIL watchdog: cycles %0d expected below 60000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, nm, act, exp);
        end
    endtask

    // One cycle: drive inputs after the falling edge, then sample outputs.
    task automatic step(input logic rn, input logic c, input logic w, input logic r,
                        input logic el, input logic er, input logic ea, input string tag);
        @(negedge clk);
        rst_n = rn; clr = c; wr_req = w; rd_req = r;
        #1;
        chk(tag, "addr_latch", addr_latch, el);
        chk(tag, "rw_n", rw_n, er);
        chk(tag, "ack", ack, ea);
    endtask

    // Model cycle used by the sweep; expected values follow R1, R3-R9.
    task automatic mstep(input logic c, input logic w, input logic r);
        logic idle, el, er, ea;
        idle = (mstate == 0);
        el = !c && idle && (w || r);
        er = c || (mstate != 2);
        ea = !c && (mstate == 2 || mstate == 3);
        @(negedge clk);
        rst_n = 1'b1; clr = c; wr_req = w; rd_req = r;
        #1;
        chk("R3 sweep", "addr_latch", addr_latch, el);
        chk("R7 sweep", "rw_n", rw_n, er);
        chk("R8 sweep", "ack", ack, ea);
        if (c) mstate = 0;
        else if (idle) mstate = w ? 1 : (r ? 3 : 0);
        else if (mstate == 1) mstate = 2;
        else mstate = 0;
    endtask

    initial begin
        // R2: reset state, including a request while reset is low.
        step(0, 0, 0, 0, 0, 1, 0, "R2 reset");
        step(0, 0, 1, 1, 0, 1, 0, "R2 request in reset");
        step(1, 0, 0, 0, 0, 1, 0, "R2 idle after reset");
        // R1: clear held for several cycles while requests toggle.
        step(1, 1, 1, 0, 0, 1, 0, "R1 clear wr");
        step(1, 1, 0, 1, 0, 1, 0, "R1 clear rd");
        step(1, 1, 1, 1, 0, 1, 0, "R1 clear both");
        step(1, 0, 0, 0, 0, 1, 0, "R1 idle after clear");
        // R3/R5: write-only sequence.
        step(1, 0, 1, 0, 1, 1, 0, "R3 write strobe");
        step(1, 0, 0, 0, 0, 1, 0, "R5 write quiet");
        step(1, 0, 0, 0, 0, 0, 1, "R5 write ack");
        step(1, 0, 0, 0, 0, 1, 0, "R8 ack one cycle");
        // R4: both requests, write wins.
        step(1, 0, 1, 1, 1, 1, 0, "R4 both strobe");
        step(1, 0, 0, 0, 0, 1, 0, "R4 write quiet not read ack");
        step(1, 0, 0, 0, 0, 0, 1, "R4 write ack");
        step(1, 0, 0, 0, 0, 1, 0, "R4 back to idle");
        // R6: read-only sequence.
        step(1, 0, 0, 1, 1, 1, 0, "R6 read strobe");
        step(1, 0, 0, 0, 0, 1, 1, "R6 read ack rw high");
        step(1, 0, 0, 0, 0, 1, 0, "R6 back to idle");
        // R9: requests during a running write are dropped.
        step(1, 0, 1, 0, 1, 1, 0, "R9 write strobe");
        step(1, 0, 0, 1, 0, 1, 0, "R9 read in wait dropped");
        step(1, 0, 1, 0, 0, 0, 1, "R9 write in ack dropped");
        step(1, 0, 0, 0, 0, 1, 0, "R9 nothing queued");
        step(1, 0, 0, 0, 0, 1, 0, "R9 still idle");
        // R10: clear aborts a running write.
        step(1, 0, 1, 0, 1, 1, 0, "R10 write strobe");
        step(1, 1, 0, 0, 0, 1, 0, "R10 clear in wait");
        step(1, 0, 0, 0, 0, 1, 0, "R10 no ack after abort");
        step(1, 0, 0, 0, 0, 1, 0, "R10 idle");
        // R2: reset during a read aborts it.
        step(1, 0, 0, 1, 1, 1, 0, "R2 read strobe");
        step(0, 0, 0, 0, 0, 1, 0, "R2 reset in read");
        step(1, 0, 0, 0, 0, 1, 0, "R2 no ack after reset");
        // Exhaustive sweep of all three-cycle patterns of clear/write/read.
        mstate = 0;
        for (int s = 0; s < 512; s++) begin
            for (int k = 0; k < 3; k++) begin
                int b;
                b = (s >> (3 * k)) & 7;
                mstep(b[2], b[1], b[0]);
            end
            for (int d = 0; d < 3; d++) mstep(1'b0, 1'b0, 1'b0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule